// File: doc/BRIEF.md
# Packet-Atomic Readback FIFO

This block buffers configuration readback data on its way from the row logic to the system bus. The row logic delivers data in packets of four 32-bit words. A packet is stored only if there is room for the whole packet. Otherwise it is discarded whole, and a one-cycle error flag is raised. The bus side drains the buffer one word per read strobe, oldest word first.

A read that finds the buffer empty does not stall. It returns zero and leaves the buffer as it was. A bus write aimed at the read port does nothing except raise its own error flag. Occupancy and an empty indication are always visible, so software can pace its reads.

Top module: `rbk_fifo`

## Requirements
- R1: The capacity is DEPTH words (default 2048, which is 8 KiB). `level` always reports the number of stored words, in the range 0 to DEPTH. `empty` is high exactly when `level` is 0.
- R2: A packet offered with `pkt_valid` is accepted when at least four entries are free. Acceptance adds 4 to `level`. Its words are later read out in the order word 0 (`pkt_data[31:0]`), word 1, word 2, word 3 (`pkt_data[127:96]`).
- R3: A packet offered while fewer than four entries are free is dropped whole and `level` does not grow. `drop_err` is high for exactly the one cycle after that offer.
- R4: A read strobe on a non-empty FIFO removes the oldest word. That word appears on `rd_data` one cycle after the strobe. `rd_data` holds its value until the next strobe.
- R5: A read strobe while empty sets `rd_data` to 0 in the following cycle and leaves `level` unchanged.
- R6: A bus write (`bus_wr`) changes neither the stored words nor `level`. `wr_err` is high for exactly the one cycle after it.
- R7: Reset (active-low `rst_n`) empties the FIFO and clears `rd_data`, `drop_err` and `wr_err`.
- R8: When a packet and a read strobe arrive in the same cycle, the room check uses the occupancy before the read. For example, at level DEPTH-3 the packet is dropped and the level ends at DEPTH-4. At level DEPTH-4 the packet is accepted and the level ends at DEPTH-1.
- R9: Word order is preserved when the storage pointers wrap past the end of the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pkt_valid | input | 1 | A four-word packet is offered this cycle |
| pkt_data | input | 128 | Packet words, word 0 in bits 31:0 |
| rd_en | input | 1 | Bus read strobe, one word per cycle |
| bus_wr | input | 1 | Bus write to the read port (rejected) |
| rd_data | output | 32 | Word from the last read, 0 if the FIFO was empty |
| level | output | 12 | Number of stored words |
| empty | output | 1 | FIFO holds no words |
| drop_err | output | 1 | Pulse: last offered packet was dropped |
| wr_err | output | 1 | Pulse: last bus write was rejected |

## Verification
The risky overlap is a packet arrival and a bus read in the same cycle, especially near full. Here the room decision must be based on the occupancy before the read. The bench first fills the FIFO to capacity. It then backs off to exactly three and then exactly four free entries, and at each point drives `pkt_valid` and `rd_en` together. A queue model decides admission from its own pre-read size and pops before pushing. The bench compares the level, the drop pulse and the returned word against that model, and also checks the directly computed levels DEPTH-4 and DEPTH-1.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
    localparam int unsigned WORD_W    = 32;
    localparam int unsigned PKT_WORDS = 4;
    localparam int unsigned LANE_W    = $clog2(PKT_WORDS);

    typedef logic [WORD_W-1:0] word_t;
    typedef word_t [PKT_WORDS-1:0] pkt_t;
endpackage

// File: rtl/rbk_bank.sv
module rbk_bank #(
    parameter int unsigned ROWS = 512,
    localparam int unsigned RW  = $clog2(ROWS)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [RW-1:0]       waddr,
    input  rbk_pkg::word_t      wdata,
    input  logic [RW-1:0]       raddr,
    output rbk_pkg::word_t      rdata
);
    rbk_pkg::word_t mem_q [ROWS];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/rbk_ctrl.sv
module rbk_ctrl #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned RW   = AW - rbk_pkg::LANE_W,
    localparam int unsigned CW   = AW + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pkt_valid,
    input  logic                 rd_en,
    input  logic                 bus_wr,
    input  rbk_pkg::word_t       rd_word,
    output logic                 push,
    output logic [RW-1:0]        wrow,
    output logic [AW-1:0]        rptr,
    output rbk_pkg::word_t       rd_data,
    output logic [CW-1:0]        level,
    output logic                 empty,
    output logic                 drop_err,
    output logic                 wr_err
);
    localparam logic [CW-1:0] ROOM_LIMIT = CW'(DEPTH - rbk_pkg::PKT_WORDS);
    localparam logic [CW-1:0] PKT_CNT    = CW'(rbk_pkg::PKT_WORDS);
    localparam logic [CW-1:0] FULL_CNT   = CW'(DEPTH);

    typedef struct packed {
        logic [RW-1:0]  wrow;
        logic [AW-1:0]  rptr;
        logic [CW-1:0]  count;
        rbk_pkg::word_t rd_data;
        logic           drop_err;
        logic           wr_err;
    } state_t;

    state_t s_d, s_q;
    logic   has_room;
    logic   pop;

    always_comb begin
        s_d      = s_q;
        has_room = (s_q.count <= ROOM_LIMIT);
        push     = pkt_valid && has_room;
        pop      = rd_en && (s_q.count != '0);

        s_d.drop_err = pkt_valid && !has_room;
        s_d.wr_err   = bus_wr;

        if (push) begin
            s_d.wrow = s_q.wrow + 1'b1;
        end
        if (pop) begin
            s_d.rptr = s_q.rptr + 1'b1;
        end
        if (rd_en) begin
            s_d.rd_data = pop ? rd_word : '0;
        end
        s_d.count = s_q.count + (push ? PKT_CNT : '0) - (pop ? CW'(1) : '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wrow     = s_q.wrow;
    assign rptr     = s_q.rptr;
    assign rd_data  = s_q.rd_data;
    assign level    = s_q.count;
    assign empty    = (s_q.count == '0);
    assign drop_err = s_q.drop_err;
    assign wr_err   = s_q.wr_err;

    // R1
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT);

    // R3
    drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && level > ROOM_LIMIT) |=> (drop_err && level <= $past(level)));

    // R5
    empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && empty && !pkt_valid) |=> (rd_data == '0 && empty));

    // R6
    bus_wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && !pkt_valid && !rd_en) |=> (wr_err && $stable(level)));

    // R8
    push_with_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && rd_en && !empty && level <= ROOM_LIMIT)
            |=> (level == $past(level) + CW'(3)));
endmodule

// File: rtl/rbk_fifo.sv
module rbk_fifo #(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW   = $clog2(DEPTH),
    localparam int unsigned RW   = AW - rbk_pkg::LANE_W,
    localparam int unsigned ROWS = DEPTH / rbk_pkg::PKT_WORDS,
    localparam int unsigned PW   = rbk_pkg::PKT_WORDS * rbk_pkg::WORD_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pkt_valid,
    input  logic [PW-1:0]                 pkt_data,
    input  logic                          rd_en,
    input  logic                          bus_wr,
    output logic [rbk_pkg::WORD_W-1:0]    rd_data,
    output logic [AW:0]                   level,
    output logic                          empty,
    output logic                          drop_err,
    output logic                          wr_err
);
    rbk_pkg::pkt_t  pkt_words;
    rbk_pkg::word_t lane_rdata [rbk_pkg::PKT_WORDS];
    rbk_pkg::word_t rd_word;
    logic           push;
    logic [RW-1:0]  wrow;
    logic [AW-1:0]  rptr;

    assign pkt_words = pkt_data;

    for (genvar k = 0; k < rbk_pkg::PKT_WORDS; k++) begin : g_lane
        rbk_bank #(.ROWS(ROWS)) i_bank (
            .clk   (clk),
            .we    (push),
            .waddr (wrow),
            .wdata (pkt_words[k]),
            .raddr (rptr[AW-1:rbk_pkg::LANE_W]),
            .rdata (lane_rdata[k])
        );
    end

    assign rd_word = lane_rdata[rptr[rbk_pkg::LANE_W-1:0]];

    rbk_ctrl #(.DEPTH(DEPTH)) i_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pkt_valid (pkt_valid),
        .rd_en     (rd_en),
        .bus_wr    (bus_wr),
        .rd_word   (rd_word),
        .push      (push),
        .wrow      (wrow),
        .rptr      (rptr),
        .rd_data   (rd_data),
        .level     (level),
        .empty     (empty),
        .drop_err  (drop_err),
        .wr_err    (wr_err)
    );
endmodule

// File: tb/test_rbk_fifo.sv
`timescale 1ns/1ps
module test_rbk_fifo;
    localparam int DEPTH = 2048;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         pkt_valid = 1'b0;
    logic [127:0] pkt_data = '0;
    logic         rd_en = 1'b0;
    logic         bus_wr = 1'b0;
    logic [31:0]  rd_data;
    logic [11:0]  level;
    logic         empty;
    logic         drop_err;
    logic         wr_err;

    int n_checks = 0;
    int n_fails  = 0;
    int pkt_seq  = 0;
    string phase_tag = "R4";

    always #5 clk = ~clk;

    rbk_fifo #(.DEPTH(DEPTH)) i_rbk_fifo (
        .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_data(pkt_data),
        .rd_en(rd_en), .bus_wr(bus_wr), .rd_data(rd_data), .level(level),
        .empty(empty), .drop_err(drop_err), .wr_err(wr_err)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Scoreboard model, updated at each rising edge from the requirements.
    logic [31:0] model_q[$];
    logic [31:0] exp_rd = '0;
    bit          exp_rd_empty = 1'b0;
    bit          exp_drop = 1'b0;
    bit          exp_wr = 1'b0;
    int          occ;
    bit          room;

    always @(posedge clk) begin
        if (!rst_n) begin
            model_q.delete();
            exp_rd = '0; exp_drop = 1'b0; exp_wr = 1'b0; exp_rd_empty = 1'b0;
        end else begin
            occ  = model_q.size();
            room = (DEPTH - occ) >= 4;
            exp_drop = pkt_valid && !room;
            exp_wr   = bus_wr;
            if (rd_en) begin
                exp_rd_empty = (occ == 0);
                exp_rd = (occ == 0) ? 32'h0 : model_q.pop_front();
            end
            if (pkt_valid && room) begin
                for (int k = 0; k < 4; k++) model_q.push_back(pkt_data[k*32 +: 32]);
            end
        end
    end

    // Monitor: compares outputs with the model away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(level == 12'(model_q.size()), "R1 level", 32'(level), 32'(model_q.size()));
            check(empty == (model_q.size() == 0), "R1 empty", 32'(empty), 32'(model_q.size() == 0));
            check(drop_err == exp_drop, "R3 drop_err", 32'(drop_err), 32'(exp_drop));
            check(wr_err == exp_wr, "R6 wr_err", 32'(wr_err), 32'(exp_wr));
            check(rd_data == exp_rd, exp_rd_empty ? "R5 rd_data" : phase_tag, rd_data, exp_rd);
        end
    end

    task automatic step(input bit pv, input bit rd, input bit wr);
        @(negedge clk);
        pkt_valid = pv;
        rd_en     = rd;
        bus_wr    = wr;
        if (pv) begin
            for (int k = 0; k < 4; k++) pkt_data[k*32 +: 32] = {16'(pkt_seq), 16'(k + 16'hA0)};
            pkt_seq++;
        end
        @(posedge clk);
        #1;
        pkt_valid = 1'b0; rd_en = 1'b0; bus_wr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        n_fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R7: state during reset
        check(level == 0 && empty, "R7 reset level", 32'(level), 0);
        check(rd_data == 0 && !drop_err && !wr_err, "R7 reset flags", rd_data, 0);
        @(negedge clk); rst_n = 1'b1;

        // R5: read on empty
        step(0, 1, 0);
        check(rd_data == 0 && level == 0, "R5 empty read", rd_data, 0);

        // R2: two packets read back in order
        phase_tag = "R2";
        step(1, 0, 0);
        step(1, 0, 0);
        check(level == 8, "R2 level after two packets", 32'(level), 8);
        step(0, 1, 0);
        check(rd_data == 32'h000000A0, "R2 first word", rd_data, 32'h000000A0);
        // R6: bus write has no effect on content
        step(0, 0, 1);
        check(wr_err && level == 7, "R6 write rejected", 32'(level), 7);
        for (int i = 0; i < 7; i++) step(0, 1, 0);
        check(rd_data == 32'h000100A3 && empty, "R2 last word", rd_data, 32'h000100A3);

        // Fill to capacity
        phase_tag = "R4";
        for (int i = 0; i < DEPTH / 4; i++) step(1, 0, 0);
        check(level == 12'(DEPTH), "R1 full level", 32'(level), DEPTH);
        step(1, 0, 0);
        check(drop_err && level == 12'(DEPTH), "R3 drop when full", 32'(level), DEPTH);
        step(0, 1, 0);
        step(1, 0, 0);
        check(drop_err && level == 12'(DEPTH - 1), "R3 drop with one free", 32'(level), DEPTH - 1);
        step(0, 1, 0);
        step(0, 1, 0);
        // R8: three free, push + read together -> dropped
        step(1, 1, 0);
        check(drop_err && level == 12'(DEPTH - 4), "R8 pre-read room drop", 32'(level), DEPTH - 4);
        // R8: four free, push + read together -> accepted
        step(1, 1, 0);
        check(!drop_err && level == 12'(DEPTH - 1), "R8 pre-read room accept", 32'(level), DEPTH - 1);

        // R9: drain across pointer wrap
        phase_tag = "R9";
        for (int i = 0; i < DEPTH - 1; i++) step(0, 1, 0);
        check(empty, "R9 drained", 32'(level), 0);
        step(0, 1, 0);

        // R7: reset while holding data
        step(1, 0, 0);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        check(level == 0 && empty && rd_data == 0, "R7 reset empties", 32'(level), 0);
        @(negedge clk); rst_n = 1'b1;
        step(0, 1, 0);
        check(rd_data == 0, "R7 nothing left after reset", rd_data, 0);

        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end
endmodule